// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds four 32-bit event counters, a sampled instruction address register, and the decode for a register-number access port. Each counter watches one line of a shared event bus. The line is picked by a select field taken from one of two mode words that the surrounding logic supplies. Every cycle in which the selected line is high, the counter adds one.

The most significant bit of each counter is an overflow flag. It is set when the count moves from 0x7FFFFFFF to 0x80000000. When the first flag in the bank becomes set, the monitor interrupt request rises. On that same edge the sample register captures an instruction address. The address comes from the threshold input when the overflow was caused by a threshold event. Otherwise it is the address of the last completed instruction. The request stays high until software has cleared every set flag by writing the counters.

Supervisor code reads and writes the counters and the sample register through the access port. Every counter can also be read, by any privilege level, at a second user number. Non-supervisor attempts to reach protected state are blocked and reported on an error strobe.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all four counters and the sample register read zero and `irq` is low.
- R2: Counter 1 selects event line `mode0[12:6]`, counter 2 selects `mode0[5:0]`, counter 3 selects `mode1[31:27]` and counter 4 selects `mode1[26:22]`. A counter adds one on every clock edge at which its selected `ev` line is high.
- R3: With `acc_sup` high, numbers 953, 954, 957 and 958 read and write counters 1 to 4. A written value is returned by the next read. Reads are combinational in the access cycle. Numbers that match nothing read zero.
- R4: Numbers 937, 938, 941 and 942 return counters 1 to 4 at any privilege level. A write to any of these numbers is ignored, and a supervisor write to them raises no error.
- R5: A supervisor write to a counter takes priority over an event increment in the same cycle.
- R6: Bit 31 of a counter is its overflow flag. Counting from 0x7FFFFFFF gives 0x80000000. A counter at 0xFFFFFFFF holds its value. A written value with bit 31 set sets the flag directly. Only a write clears the flag.
- R7: `irq` is high exactly while at least one counter has bit 31 set. It rises in the cycle after the edge that sets the first flag.
- R8: On the edge where `irq` goes from low to high, the sample register (number 955, supervisor read/write) loads `thr_addr` if `thr_hit` is high, else `done_addr`. It changes otherwise only through a supervisor write to 955. A capture wins over a write in the same cycle.
- R9: With `acc_sup` low, any write is ignored and pulses `acc_err`. A read of 953, 954, 955, 957 or 958 returns zero and pulses `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev | input | EVW | Event lines, one per event code |
| mode0 | input | 32 | Mode word holding the select fields for counters 1 and 2 |
| mode1 | input | 32 | Mode word holding the select fields for counters 3 and 4 |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sup | input | 1 | Access is made at supervisor level |
| acc_num | input | NW | Register number |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| acc_err | output | 1 | Privilege violation strobe |
| thr_hit | input | 1 | The current overflow comes from a threshold event |
| thr_addr | input | 32 | Address of the instruction that crossed the threshold |
| done_addr | input | 32 | Address of the last instruction completed this cycle |
| irq | output | 1 | Monitor interrupt request |

## Verification
The checker assumes that `acc_valid` is low during reset. It also assumes that `acc_num`, `acc_write` and `acc_sup` are meaningful only while `acc_valid` is high. This matters because the sample-register and flag properties look one cycle back at the access fields to excuse a change. The stimulus holds the access port idle through reset and drives one access per cycle, always with defined fields. It changes `thr_hit` and the two address inputs only in cycles where no flag can rise, so the expected capture is unambiguous.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int W   = 32,
  parameter int EVW = 128,
  parameter int NW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] ev,
  input  logic [31:0]    mode0,
  input  logic [31:0]    mode1,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic           acc_sup,
  input  logic [NW-1:0]  acc_num,
  input  logic [W-1:0]   acc_wdata,
  output logic [W-1:0]   acc_rdata,
  output logic           acc_err,
  input  logic           thr_hit,
  input  logic [W-1:0]   thr_addr,
  input  logic [W-1:0]   done_addr,
  output logic           irq
);
  localparam int NC = 4;

  logic [NC-1:0][W-1:0] cnt, cnt_nxt;
  logic [W-1:0]         sia;
  logic [NC-1:0][6:0]   sel;
  logic [NC-1:0]        hit_sup, hit_usr, flag_now, flag_nxt;
  logic                 hit_sia, wr;

  // Mode-word bits a:b (bit 0 = MSB) map to [31-a:31-b]
  assign sel[0] = mode0[12:6];
  assign sel[1] = {1'b0, mode0[5:0]};
  assign sel[2] = {2'b0, mode1[31:27]};
  assign sel[3] = {2'b0, mode1[26:22]};

  assign hit_sup = {acc_num == NW'(958), acc_num == NW'(957),
                    acc_num == NW'(954), acc_num == NW'(953)};
  assign hit_usr = {acc_num == NW'(942), acc_num == NW'(941),
                    acc_num == NW'(938), acc_num == NW'(937)};
  assign hit_sia = acc_num == NW'(955);
  assign wr      = acc_valid & acc_write & acc_sup;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      cnt_nxt[i] = cnt[i];
      if (wr && hit_sup[i])
        cnt_nxt[i] = acc_wdata;
      else if (ev[sel[i]] && cnt[i] != '1)
        cnt_nxt[i] = cnt[i] + W'(1);
      flag_now[i] = cnt[i][W-1];
      flag_nxt[i] = cnt_nxt[i][W-1];
    end
  end

  assign irq = |flag_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sia <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (|flag_nxt && !(|flag_now))
        sia <= thr_hit ? thr_addr : done_addr;
      else if (wr && hit_sia)
        sia <= acc_wdata;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      for (int i = 0; i < NC; i++)
        if (hit_usr[i] || (acc_sup && hit_sup[i])) acc_rdata = cnt[i];
      if (acc_sup && hit_sia) acc_rdata = sia;
    end
  end

  assign acc_err = acc_valid & ~acc_sup & (acc_write | (|hit_sup) | hit_sia);
endmodule

module perf_counter_bank_chk #(
  parameter int W  = 32,
  parameter int NW = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                acc_write,
  input logic                acc_sup,
  input logic [NW-1:0]       acc_num,
  input logic [W-1:0]        acc_rdata,
  input logic                acc_err,
  input logic                irq,
  input logic [3:0][W-1:0]   cnt,
  input logic [W-1:0]        sia
);
  logic sup_wr, sia_wr, prot_num;
  logic [3:0] cnt_wr;
  assign sup_wr   = acc_valid && acc_write && acc_sup;
  assign sia_wr   = sup_wr && acc_num == NW'(955);
  assign cnt_wr   = {4{sup_wr}} & {acc_num == NW'(958), acc_num == NW'(957),
                                   acc_num == NW'(954), acc_num == NW'(953)};
  assign prot_num = acc_num == NW'(953) || acc_num == NW'(954) || acc_num == NW'(955)
                 || acc_num == NW'(957) || acc_num == NW'(958);

  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !sup_wr |=> irq);

  a_r8_sia_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sia) |-> ($rose(irq) || $past(sia_wr)));

  a_r9_user_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && !acc_sup |-> acc_err);

  a_r9_user_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && !acc_sup && prot_num |-> acc_rdata == '0 && acc_err);

  a_r4_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && acc_num == NW'(941) |-> acc_rdata == cnt[2]);

  for (genvar i = 0; i < 4; i++) begin : g_flag
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnt[i][W-1]) |-> $past(cnt_wr[i]));
  end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.W(W), .NW(NW)) i_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sup(acc_sup), .acc_num(acc_num), .acc_rdata(acc_rdata), .acc_err(acc_err),
  .irq(irq), .cnt(cnt), .sia(sia)
);

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  typedef struct {
    logic        is_wr;
    logic [31:0] data;
    logic        err;
    string       tag;
  } item_t;

  logic         clk = 0, rst_n = 0;
  logic [127:0] ev = '0;
  logic [31:0]  mode0 = '0, mode1 = '0;
  logic         acc_valid = 0, acc_write = 0, acc_sup = 0;
  logic [9:0]   acc_num = '0;
  logic [31:0]  acc_wdata = '0, acc_rdata;
  logic         acc_err, irq;
  logic         thr_hit = 0;
  logic [31:0]  thr_addr = '0, done_addr = '0;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  item_t sb[$];

  always #5 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .ev(ev), .mode0(mode0), .mode1(mode1),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sup(acc_sup),
    .acc_num(acc_num), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .thr_hit(thr_hit), .thr_addr(thr_addr),
    .done_addr(done_addr), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares every access against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: access with no expected item, actual %h expected none", acc_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " err"}, {31'b0, acc_err}, {31'b0, it.err});
        if (!it.is_wr) chk({it.tag, " data"}, acc_rdata, it.data);
      end
    end
  end

  task automatic access(bit w, logic [9:0] num, bit sup, logic [31:0] d,
                        logic [31:0] exp, bit experr, string tag);
    item_t it;
    it.is_wr = w; it.data = exp; it.err = experr; it.tag = tag;
    sb.push_back(it);
    acc_valid = 1; acc_write = w; acc_num = num; acc_sup = sup; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(logic [9:0] num, bit sup, logic [31:0] exp, bit experr, string tag);
    access(0, num, sup, '0, exp, experr, tag);
  endtask

  task automatic wr(logic [9:0] num, bit sup, logic [31:0] d, bit experr, string tag);
    access(1, num, sup, d, '0, experr, tag);
  endtask

  task automatic pulse(logic [127:0] bits);
    ev = bits;
    @(posedge clk); #1;
    ev = '0;
  endtask

  function automatic logic [127:0] b(int n);
    return 128'(1) << n;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mode0 = (32'd5 << 6) | 32'd10;
    mode1 = (32'd20 << 27) | (32'd31 << 22);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(953, 1, 0, 0, "R1 cnt1");
    rd(958, 1, 0, 0, "R1 cnt4");
    rd(955, 1, 0, 0, "R1 sia");

    // R2 selection and counting
    pulse(b(5));
    pulse(b(5) | b(20));
    pulse(b(5) | b(10) | b(20) | b(31));
    pulse(b(6) | b(11) | b(21) | b(30));
    rd(953, 1, 3, 0, "R2 cnt1");
    rd(954, 1, 1, 0, "R2 cnt2");
    rd(957, 1, 2, 0, "R2 cnt3");
    rd(958, 1, 1, 0, "R2 cnt4");

    // R4 aliases at user level
    rd(937, 0, 3, 0, "R4 alias1");
    rd(938, 0, 1, 0, "R4 alias2");
    rd(941, 0, 2, 0, "R4 alias3");
    rd(942, 0, 1, 0, "R4 alias4");

    // R3 write / read back, unknown number
    wr(954, 1, 32'h1234_5678, 0, "R3 write cnt2");
    rd(954, 1, 32'h1234_5678, 0, "R3 readback cnt2");
    rd(900, 1, 0, 0, "R3 unknown number");

    // R5 write beats increment
    ev = b(10);
    wr(954, 1, 32'h100, 0, "R5 write with event");
    ev = '0;
    rd(954, 1, 32'h100, 0, "R5 write wins");

    // R4 supervisor write to alias ignored
    wr(938, 1, 32'hFFFF, 0, "R4 alias write");
    rd(954, 1, 32'h100, 0, "R4 alias write ignored");

    // R9 user-level protection
    wr(953, 0, 32'hDEAD, 1, "R9 user write");
    rd(953, 1, 3, 0, "R9 user write ignored");
    rd(953, 0, 0, 1, "R9 user read cnt1");
    rd(955, 0, 0, 1, "R9 user read sia");
    wr(955, 0, 32'h5555, 1, "R9 user write sia");
    rd(955, 1, 0, 0, "R9 sia unchanged");

    // R6/R7/R8 overflow from counting, non-threshold cause
    wr(957, 1, 32'h7FFF_FFFF, 0, "R6 preset cnt3");
    chk("R7 irq low before overflow", {31'b0, irq}, 0);
    done_addr = 32'hAAAA_0000; thr_addr = 32'hBBBB_0000; thr_hit = 0;
    pulse(b(20));
    chk("R7 irq rises", {31'b0, irq}, 1);
    rd(941, 0, 32'h8000_0000, 0, "R6 overflow value");
    rd(955, 1, 32'hAAAA_0000, 0, "R8 last-completed capture");
    done_addr = 32'hAAAA_1111;
    pulse(b(20));
    repeat (3) @(posedge clk); #1;
    chk("R7 irq held", {31'b0, irq}, 1);
    rd(957, 1, 32'h8000_0001, 0, "R6 keeps counting");
    rd(955, 1, 32'hAAAA_0000, 0, "R8 no recapture");
    wr(957, 1, 0, 0, "R7 clear cnt3");
    chk("R7 irq cleared", {31'b0, irq}, 0);

    // R8 threshold cause
    wr(953, 1, 32'h7FFF_FFFF, 0, "R8 preset cnt1");
    thr_hit = 1;
    pulse(b(5));
    thr_hit = 0;
    chk("R7 irq from cnt1", {31'b0, irq}, 1);
    rd(955, 1, 32'hBBBB_0000, 0, "R8 threshold capture");

    // R6 saturation while irq already high, R8 no reload
    wr(958, 1, 32'hFFFF_FFFF, 0, "R6 preset cnt4");
    pulse(b(31));
    rd(942, 0, 32'hFFFF_FFFF, 0, "R6 saturate");
    rd(955, 1, 32'hBBBB_0000, 0, "R8 no reload second flag");
    wr(953, 1, 0, 0, "R7 clear cnt1");
    chk("R7 irq stays with cnt4 flag", {31'b0, irq}, 1);
    wr(958, 1, 5, 0, "R7 clear cnt4");
    chk("R7 irq low all clear", {31'b0, irq}, 0);

    // R6 flag set directly by write, R8 capture on it
    done_addr = 32'hCCCC_0000;
    wr(954, 1, 32'h8000_0000, 0, "R6 write flag");
    chk("R7 irq on written flag", {31'b0, irq}, 1);
    rd(955, 1, 32'hCCCC_0000, 0, "R8 capture on write");
    wr(954, 1, 0, 0, "R7 clear cnt2");

    // R8 direct supervisor write
    wr(955, 1, 32'h1357_2468, 0, "R8 sia write");
    rd(955, 1, 32'h1357_2468, 0, "R8 sia readback");

    repeat (2) @(posedge clk); #1;
    chk("scoreboard drained", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule